// File: doc/BRIEF.md
# ATA DMA Command Sequencer

This block is the host-side engine for a single DMA read or DMA write command against a disk-style device. Software presents one request with the opcode, features, sector count, sector number, 16-bit cylinder and device/head bytes, plus a direction bit. The block then works through a fixed sequence. It arms the slave DMA channel and writes the six parameter bytes in a fixed address order. It writes the opcode, moves 16-bit words while the device holds its DMA request, and accepts exactly one completion interrupt for the whole multisector command. It disarms the channel, reads status, and reads the error register only when status flags an error.

The transfer length is checked against the request. A sector holds 2^SECT_LG2 words (256 by default), and a sector count of zero means 2^CNT_W sectors. An interrupt that arrives before the expected number of words has moved is a protocol error. The final status and error bytes are latched and announced with a one-cycle done pulse. New requests are refused while a command is in flight.

Top module: `ata_dma_seq`

## Requirements
- R1: `chan_arm` is high for exactly one cycle, in the cycle just before the first task-file write. In that cycle `chan_write` equals the request's direction bit (1 = write DMA, host to device).
- R2: After arming, `tf_wr` is high for seven consecutive cycles with `tf_addr` 1,2,3,4,5,6,7. The matching `tf_wdata` values are features, sector count, sector number, cylinder bits 7:0, cylinder bits 15:8, device/head, and then the opcode.
- R3: `dma_ack` is high only in a cycle where `dev_dmarq` is high. Over one command it is high exactly count×256 times, where a count of 0 means 256 sectors. Once that many words have moved, a still-asserted `dev_dmarq` receives no further `dma_ack`.
- R4: The words may arrive in any number of bursts separated by gaps. A single `dev_intrq` pulse that comes after the last word, or in the same cycle as the last word, ends the data phase with `proto_err` low.
- R5: A `dev_intrq` pulse during the data phase before all words have moved ends the data phase and sets `proto_err`, which is high when `done` pulses.
- R6: After the data phase ends, `chan_disarm` is high for one cycle. The status read (`tf_rd` with `tf_addr` 7) follows in the very next cycle.
- R7: The error register read (`tf_rd` with `tf_addr` 1) happens in the cycle after the status read if and only if bit 0 of the status byte is 1. Otherwise no error read occurs and `err_o` is 0.
- R8: `done` is a one-cycle pulse. While `done` is high, `stat_o` and `err_o` hold the bytes read, and they stay held until the next accepted request.
- R9: `busy` is high from the cycle after `req_valid` is accepted through the `done` cycle, and low otherwise. A `req_valid` seen while `busy` is high has no effect.
- R10: In each `dma_ack` cycle, `host_pop` is high for a write DMA and `host_push` is high for a read DMA. `dev_data_o` carries `host_data_i`, and `host_data_o` carries `dev_data_i`.
- R11: After reset, `busy`, `done`, `chan_arm`, `chan_disarm`, `tf_wr`, `tf_rd`, `dma_ack` and `proto_err` are 0, and `stat_o` and `err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Command request strobe, taken when not busy |
| req_write | input | 1 | 1 = write DMA, 0 = read DMA |
| req_opcode | input | 8 | Command opcode byte |
| req_features | input | 8 | Features byte |
| req_count | input | CNT_W | Sector count (0 = 2^CNT_W sectors) |
| req_sector | input | 8 | Sector number byte |
| req_cyl | input | 16 | Cylinder |
| req_devhd | input | 8 | Device/head byte |
| busy | output | 1 | Command in flight, requests refused |
| chan_arm | output | 1 | Arm the slave DMA channel |
| chan_write | output | 1 | Direction for the armed channel |
| chan_disarm | output | 1 | Release the slave DMA channel |
| tf_wr | output | 1 | Task-file register write strobe |
| tf_rd | output | 1 | Task-file register read strobe |
| tf_addr | output | ADDR_W | Task-file register address |
| tf_wdata | output | 8 | Task-file write data |
| tf_rdata | input | 8 | Task-file read data, valid in the read cycle |
| dev_dmarq | input | 1 | Device DMA request |
| dma_ack | output | 1 | One word moves this cycle |
| dev_data_i | input | DATA_W | Word from device (read DMA) |
| dev_data_o | output | DATA_W | Word to device (write DMA) |
| host_data_i | input | DATA_W | Word from host buffer |
| host_data_o | output | DATA_W | Word to host buffer |
| host_pop | output | 1 | Host buffer word consumed |
| host_push | output | 1 | Host buffer word written |
| dev_intrq | input | 1 | Device completion interrupt |
| done | output | 1 | One-cycle completion pulse |
| stat_o | output | 8 | Latched status byte |
| err_o | output | 8 | Latched error byte, 0 if not read |
| proto_err | output | 1 | Interrupt came before all words moved |

## Verification
The final data word and the completion interrupt can land in the same cycle. The decision whether the interrupt is early therefore has to count the word that moves in that cycle. The bench provokes this by raising `dev_intrq` together with `dev_dmarq` for the last word of several commands. It judges the case by `proto_err` staying low, the acknowledged word count matching count×256, and the disarm and status read following on schedule. The opposite case is an interrupt five words short of the expected count, which must set `proto_err`.

// File: rtl/ata_dma_seq_pkg.sv
package ata_dma_seq_pkg;

   typedef enum logic [3:0] {
      S_IDLE,
      S_ARM,
      S_PARAM,
      S_CMD,
      S_XFER,
      S_DISARM,
      S_STAT,
      S_ERR,
      S_DONE
   } seq_state_t;

   // number of parameter bytes written before the opcode
   localparam int N_PARAM      = 6;
   localparam int TF_CMD_ADDR  = 7;
   localparam int TF_STAT_ADDR = 7;
   localparam int TF_ERR_ADDR  = 1;

   // register address for each parameter slot, in issue order
   function automatic int slot_addr(input int slot);
      case (slot)
         0:       return 1;  // features
         1:       return 2;  // sector count
         2:       return 3;  // sector number
         3:       return 4;  // cylinder low
         4:       return 5;  // cylinder high
         5:       return 6;  // device/head
         default: return 0;
      endcase
   endfunction

endpackage

// File: rtl/ata_seq_wordcnt.sv
module ata_seq_wordcnt #(
   parameter int CNT_W    = 8,
   parameter int SECT_LG2 = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] sectors,
   input  logic             dec,
   output logic             empty,
   output logic             drained_next
);
   localparam int WC_W = CNT_W + SECT_LG2 + 1;

   logic [WC_W-1:0] remain_q;
   logic [WC_W-1:0] load_val;

   always_comb begin
      if (sectors == '0) load_val = {1'b1, {(WC_W-1){1'b0}}};
      else               load_val = {1'b0, sectors, {SECT_LG2{1'b0}}};
   end

   assign empty        = (remain_q == '0);
   // true when nothing remains after this cycle's word
   assign drained_next = empty || (dec && (remain_q == WC_W'(1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                remain_q <= '0;
      else if (load)             remain_q <= load_val;
      else if (dec && !empty)    remain_q <= remain_q - WC_W'(1);
   end
endmodule

// File: rtl/ata_seq_fsm.sv
module ata_seq_fsm
   import ata_dma_seq_pkg::*;
#(
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             intr,
   input  logic             drained_next,
   input  logic             stat_err,
   output seq_state_t       state,
   output logic [IDX_W-1:0] pidx,
   output logic             early_int
);
   seq_state_t       state_d;
   logic [IDX_W-1:0] pidx_d;

   assign early_int = (state == S_XFER) && intr && !drained_next;

   always_comb begin
      state_d = state;
      pidx_d  = pidx;
      case (state)
         S_IDLE:   if (start) state_d = S_ARM;
         S_ARM: begin
            state_d = S_PARAM;
            pidx_d  = '0;
         end
         S_PARAM: begin
            if (pidx == IDX_W'(N_PARAM - 1)) state_d = S_CMD;
            else                             pidx_d  = pidx + IDX_W'(1);
         end
         S_CMD:    state_d = S_XFER;
         S_XFER:   if (intr) state_d = S_DISARM;
         S_DISARM: state_d = S_STAT;
         S_STAT:   state_d = stat_err ? S_ERR : S_DONE;
         S_ERR:    state_d = S_DONE;
         S_DONE:   state_d = S_IDLE;
         default:  state_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= S_IDLE;
         pidx  <= '0;
      end else begin
         state <= state_d;
         pidx  <= pidx_d;
      end
   end
endmodule

// File: rtl/ata_seq_tfbus.sv
module ata_seq_tfbus
   import ata_dma_seq_pkg::*;
#(
   parameter int ADDR_W = 3,
   parameter int CNT_W  = 8,
   parameter int IDX_W  = 3
) (
   input  seq_state_t       state,
   input  logic [IDX_W-1:0] pidx,
   input  logic [7:0]       opcode,
   input  logic [7:0]       features,
   input  logic [CNT_W-1:0] sectors,
   input  logic [7:0]       sector_no,
   input  logic [15:0]      cyl,
   input  logic [7:0]       devhd,
   output logic             tf_wr,
   output logic             tf_rd,
   output logic [ADDR_W-1:0] tf_addr,
   output logic [7:0]       tf_wdata
);
   localparam int SLOTS = 1 << IDX_W;

   logic [7:0]        cnt_byte;
   logic [7:0]        val_lut  [0:N_PARAM-1];
   logic [7:0]        slot_val [0:SLOTS-1];
   logic [ADDR_W-1:0] slot_adr [0:SLOTS-1];

   always_comb begin
      cnt_byte              = '0;
      cnt_byte[CNT_W-1:0]   = sectors;
   end

   assign val_lut = '{features, cnt_byte, sector_no, cyl[7:0], cyl[15:8], devhd};

   for (genvar g = 0; g < SLOTS; g++) begin : g_slot
      if (g < N_PARAM) begin : g_used
         assign slot_val[g] = val_lut[g];
         assign slot_adr[g] = ADDR_W'(slot_addr(g));
      end else begin : g_pad
         assign slot_val[g] = '0;
         assign slot_adr[g] = '0;
      end
   end

   always_comb begin
      tf_wr    = 1'b0;
      tf_rd    = 1'b0;
      tf_addr  = '0;
      tf_wdata = '0;
      case (state)
         S_PARAM: begin
            tf_wr    = 1'b1;
            tf_addr  = slot_adr[pidx];
            tf_wdata = slot_val[pidx];
         end
         S_CMD: begin
            tf_wr    = 1'b1;
            tf_addr  = ADDR_W'(TF_CMD_ADDR);
            tf_wdata = opcode;
         end
         S_STAT: begin
            tf_rd    = 1'b1;
            tf_addr  = ADDR_W'(TF_STAT_ADDR);
         end
         S_ERR: begin
            tf_rd    = 1'b1;
            tf_addr  = ADDR_W'(TF_ERR_ADDR);
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/ata_dma_seq.sv
module ata_dma_seq
   import ata_dma_seq_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int CNT_W    = 8,
   parameter int SECT_LG2 = 8,
   parameter int ADDR_W   = 3,
   parameter int ERR_BIT  = 0,
   parameter bit INT_SYNC = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [7:0]        req_opcode,
   input  logic [7:0]        req_features,
   input  logic [CNT_W-1:0]  req_count,
   input  logic [7:0]        req_sector,
   input  logic [15:0]       req_cyl,
   input  logic [7:0]        req_devhd,
   output logic              busy,
   output logic              chan_arm,
   output logic              chan_write,
   output logic              chan_disarm,
   output logic              tf_wr,
   output logic              tf_rd,
   output logic [ADDR_W-1:0] tf_addr,
   output logic [7:0]        tf_wdata,
   input  logic [7:0]        tf_rdata,
   input  logic              dev_dmarq,
   output logic              dma_ack,
   input  logic [DATA_W-1:0] dev_data_i,
   output logic [DATA_W-1:0] dev_data_o,
   input  logic [DATA_W-1:0] host_data_i,
   output logic [DATA_W-1:0] host_data_o,
   output logic              host_pop,
   output logic              host_push,
   input  logic              dev_intrq,
   output logic              done,
   output logic [7:0]        stat_o,
   output logic [7:0]        err_o,
   output logic              proto_err
);
   localparam int IDX_W = $clog2(N_PARAM);

   if (CNT_W < 1 || CNT_W > 8) begin : g_chk_cnt
      $error("ata_dma_seq: CNT_W must be 1..8");
   end
   if (ADDR_W < 3) begin : g_chk_addr
      $error("ata_dma_seq: ADDR_W must be at least 3");
   end
   if (ERR_BIT < 0 || ERR_BIT > 7) begin : g_chk_err
      $error("ata_dma_seq: ERR_BIT must be 0..7");
   end
   if (SECT_LG2 < 1 || DATA_W < 1) begin : g_chk_geom
      $error("ata_dma_seq: SECT_LG2 and DATA_W must be positive");
   end

   seq_state_t       state;
   logic [IDX_W-1:0] pidx;
   logic             start, intr, empty, drained_next, early_int;

   logic [7:0]       opc_q, feat_q, sect_q, devhd_q;
   logic [CNT_W-1:0] cnt_q;
   logic [15:0]      cyl_q;
   logic             wr_q;
   logic [7:0]       stat_q, err_q;
   logic             perr_q;

   assign start = req_valid && (state == S_IDLE);

   // interrupt input: direct or through a two-stage synchronizer
   if (INT_SYNC) begin : g_int_sync
      logic [1:0] sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q <= '0;
         else        sync_q <= {sync_q[0], dev_intrq};
      end
      assign intr = sync_q[1];
   end else begin : g_int_direct
      assign intr = dev_intrq;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         opc_q   <= '0;
         feat_q  <= '0;
         sect_q  <= '0;
         devhd_q <= '0;
         cnt_q   <= '0;
         cyl_q   <= '0;
         wr_q    <= 1'b0;
      end else if (start) begin
         opc_q   <= req_opcode;
         feat_q  <= req_features;
         sect_q  <= req_sector;
         devhd_q <= req_devhd;
         cnt_q   <= req_count;
         cyl_q   <= req_cyl;
         wr_q    <= req_write;
      end
   end

   ata_seq_fsm #(.IDX_W(IDX_W)) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (start),
      .intr         (intr),
      .drained_next (drained_next),
      .stat_err     (tf_rdata[ERR_BIT]),
      .state        (state),
      .pidx         (pidx),
      .early_int    (early_int)
   );

   ata_seq_wordcnt #(.CNT_W(CNT_W), .SECT_LG2(SECT_LG2)) u_cnt (
      .clk          (clk),
      .rst_n        (rst_n),
      .load         (start),
      .sectors      (req_count),
      .dec          (dma_ack),
      .empty        (empty),
      .drained_next (drained_next)
   );

   ata_seq_tfbus #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_tf (
      .state     (state),
      .pidx      (pidx),
      .opcode    (opc_q),
      .features  (feat_q),
      .sectors   (cnt_q),
      .sector_no (sect_q),
      .cyl       (cyl_q),
      .devhd     (devhd_q),
      .tf_wr     (tf_wr),
      .tf_rd     (tf_rd),
      .tf_addr   (tf_addr),
      .tf_wdata  (tf_wdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= '0;
         err_q  <= '0;
         perr_q <= 1'b0;
      end else begin
         if (start) begin
            stat_q <= '0;
            err_q  <= '0;
            perr_q <= 1'b0;
         end
         if (early_int)         perr_q <= 1'b1;
         if (state == S_STAT)   stat_q <= tf_rdata;
         if (state == S_ERR)    err_q  <= tf_rdata;
      end
   end

   assign busy        = (state != S_IDLE);
   assign chan_arm    = (state == S_ARM);
   assign chan_write  = wr_q;
   assign chan_disarm = (state == S_DISARM);
   assign dma_ack     = (state == S_XFER) && dev_dmarq && !empty;
   assign host_pop    = dma_ack && wr_q;
   assign host_push   = dma_ack && !wr_q;
   assign dev_data_o  = host_data_i;
   assign host_data_o = dev_data_i;
   assign done        = (state == S_DONE);
   assign stat_o      = stat_q;
   assign err_o       = err_q;
   assign proto_err   = perr_q;
endmodule

// File: rtl/ata_dma_seq_chk.sv
module ata_dma_seq_chk #(
   parameter int ADDR_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              chan_arm,
   input logic              chan_disarm,
   input logic              tf_wr,
   input logic              tf_rd,
   input logic [ADDR_W-1:0] tf_addr,
   input logic              stat_err,
   input logic              dev_dmarq,
   input logic              dma_ack,
   input logic              done
);
   assert_arm_then_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
      chan_arm |=> (tf_wr && !chan_arm));

   assert_cmd_after_devhd_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tf_wr && tf_addr == ADDR_W'(7)) |-> $past(tf_wr && tf_addr == ADDR_W'(6)));

   assert_ack_needs_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
      dma_ack |-> dev_dmarq);

   assert_disarm_then_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
      chan_disarm |=> (tf_rd && tf_addr == ADDR_W'(7)));

   assert_err_read_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (tf_rd && tf_addr == ADDR_W'(1)) |-> $past(tf_rd && tf_addr == ADDR_W'(7) && stat_err));

   assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_activity_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (tf_wr || tf_rd || dma_ack || chan_arm || chan_disarm) |-> busy);

   assert_one_action_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({tf_wr, tf_rd, dma_ack, chan_arm, chan_disarm, done}));
endmodule

bind ata_dma_seq ata_dma_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .busy        (busy),
   .chan_arm    (chan_arm),
   .chan_disarm (chan_disarm),
   .tf_wr       (tf_wr),
   .tf_rd       (tf_rd),
   .tf_addr     (tf_addr),
   .stat_err    (tf_rdata[ERR_BIT]),
   .dev_dmarq   (dev_dmarq),
   .dma_ack     (dma_ack),
   .done        (done)
);

// File: tb/ata_dma_seq_tb_top.sv
`timescale 1ns/1ps
module ata_dma_seq_tb_top;
   typedef struct packed {
      logic        wr;
      logic [7:0]  cnt;
      logic [15:0] burst;
      logic        same;
      logic        early;
      logic [7:0]  stat;
      logic [7:0]  errv;
   } vec_t;

   localparam int NV = 5;
   localparam vec_t VECS [0:NV-1] = '{
      '{1'b0, 8'd1, 16'd256, 1'b0, 1'b0, 8'h50, 8'hAA},
      '{1'b1, 8'd2, 16'd100, 1'b1, 1'b0, 8'h50, 8'h33},
      '{1'b0, 8'd3, 16'd7,   1'b0, 1'b1, 8'h51, 8'h04},
      '{1'b1, 8'd1, 16'd33,  1'b1, 1'b0, 8'h41, 8'h10},
      '{1'b0, 8'd2, 16'd512, 1'b0, 1'b0, 8'h58, 8'h80}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic        req_valid = 0, req_write = 0;
   logic [7:0]  req_opcode = 0, req_features = 0, req_sector = 0, req_devhd = 0;
   logic [7:0]  req_count = 0;
   logic [15:0] req_cyl = 0;
   logic        busy, chan_arm, chan_write, chan_disarm, tf_wr, tf_rd;
   logic [2:0]  tf_addr;
   logic [7:0]  tf_wdata, tf_rdata;
   logic        dev_dmarq = 0, dma_ack, dev_intrq = 0;
   logic [15:0] dev_data_i = 16'h1357, dev_data_o, host_data_i = 16'hBEEF, host_data_o;
   logic        host_pop, host_push, done, proto_err;
   logic [7:0]  stat_o, err_o;
   logic [7:0]  cur_stat = 0, cur_err = 0;

   assign tf_rdata = (tf_addr == 3'd7) ? cur_stat : cur_err;

   ata_dma_seq dut_i (.*);

   int tests = 0, fails = 0;
   bit finished = 0;

   // event log, filled away from the active edge
   int cyc = 0, nw = 0, arm_cnt = 0, arm_cyc = 0, wr0_cyc = 0, arm_dir = 0;
   int disarm_cyc = 0, stat_cyc = 0, err_cyc = 0, err_rd = 0, done_cnt = 0;
   int acks = 0, ack_bad = 0, pops = 0, pushes = 0, data_bad = 0, idle_act = 0;
   logic [2:0] wa [0:15];
   logic [7:0] wd [0:15];
   logic [7:0] done_stat, done_err;
   logic       done_perr;
   bit         cmd_seen = 0;

   always @(negedge clk) if (rst_n) begin
      cyc++;
      if (chan_arm) begin arm_cnt++; arm_cyc = cyc; arm_dir = chan_write; end
      if (tf_wr) begin
         if (nw == 0) wr0_cyc = cyc;
         if (nw < 16) begin wa[nw] = tf_addr; wd[nw] = tf_wdata; nw++; end
         if (tf_addr == 3'd7) cmd_seen = 1;
      end
      if (dma_ack) begin
         acks++;
         if (!dev_dmarq) ack_bad++;
         if (host_pop)  begin pops++;   if (dev_data_o !== host_data_i) data_bad++; end
         if (host_push) begin pushes++; if (host_data_o !== dev_data_i) data_bad++; end
      end
      if (!busy && (tf_wr || tf_rd || dma_ack || chan_arm || chan_disarm)) idle_act++;
      if (chan_disarm) disarm_cyc = cyc;
      if (tf_rd && tf_addr == 3'd7) stat_cyc = cyc;
      if (tf_rd && tf_addr == 3'd1) begin err_rd++; err_cyc = cyc; end
      if (done) begin
         done_cnt++; done_stat = stat_o; done_err = err_o; done_perr = proto_err;
      end
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic run_cmd(input vec_t v, input int idx, input int extra_hold);
      int total, limit, sent, nb, guard;
      logic [7:0]  f, s, d, o;
      logic [15:0] c;
      f = 8'h10 + 8'(idx); s = 8'h20 + 8'(idx); d = 8'hE0 | 8'(idx);
      c = 16'h1234 + 16'(idx) * 16'h0101; o = v.wr ? 8'hCA : 8'hC8;
      nw = 0; arm_cnt = 0; err_rd = 0; done_cnt = 0; acks = 0; ack_bad = 0;
      pops = 0; pushes = 0; data_bad = 0; idle_act = 0; cmd_seen = 0;
      cur_stat = v.stat; cur_err = v.errv;
      req_write = v.wr; req_count = v.cnt; req_features = f; req_sector = s;
      req_cyl = c; req_devhd = d; req_opcode = o; req_valid = 1;
      tick();
      req_valid = 0;
      guard = 0;
      while (!cmd_seen && guard < 50) begin tick(); guard++; end
      // request while busy must be refused (R9)
      req_valid = 1; req_features = 8'hFF; req_write = ~v.wr;
      tick();
      req_valid = 0;
      total = (v.cnt == 0) ? 65536 : int'(v.cnt) * 256;
      limit = v.early ? total - 5 : total;
      sent = 0;
      while (sent < limit) begin
         nb = (int'(v.burst) < limit - sent) ? int'(v.burst) : limit - sent;
         for (int k = 0; k < nb; k++) begin
            dev_dmarq = 1;
            if (v.same && !v.early && sent + 1 == limit) dev_intrq = 1;
            tick();
            sent++;
            dev_intrq = 0;
         end
         dev_dmarq = 0;
         tick(); tick();
      end
      if (extra_hold > 0) begin
         dev_dmarq = 1;
         repeat (extra_hold) tick();
         dev_dmarq = 0;
      end
      if (!(v.same && !v.early)) begin
         dev_intrq = 1; tick(); dev_intrq = 0;
      end
      guard = 0;
      while (done_cnt == 0 && guard < 20) begin tick(); guard++; end

      chk(arm_cnt == 1, "R9 single arm per command", arm_cnt, 1);
      chk(arm_cyc == wr0_cyc - 1, "R1 arm precedes first write", arm_cyc, wr0_cyc - 1);
      chk(arm_dir == int'(v.wr), "R1 channel direction", arm_dir, v.wr);
      chk(nw == 7, "R2 write count", nw, 7);
      for (int i = 0; i < 7; i++)
         chk(wa[i] == 3'(i + 1), "R2 write address order", wa[i], i + 1);
      chk(wd[0] == f && wd[1] == v.cnt && wd[2] == s, "R2 features/count/sector", {wd[0], wd[1], wd[2]}, {f, v.cnt, s});
      chk(wd[3] == c[7:0] && wd[4] == c[15:8], "R2 cylinder low/high", {wd[3], wd[4]}, c);
      chk(wd[5] == d && wd[6] == o, "R2 devhd/opcode", {wd[5], wd[6]}, {d, o});
      chk(acks == limit, "R3 word count", acks, limit);
      chk(ack_bad == 0, "R3 ack without request", ack_bad, 0);
      chk(done_perr == v.early, v.early ? "R5 early interrupt flag" : "R4 clean completion", done_perr, v.early);
      chk(stat_cyc == disarm_cyc + 1, "R6 disarm then status", stat_cyc, disarm_cyc + 1);
      chk(err_rd == int'(v.stat[0]), "R7 error read gating", err_rd, v.stat[0]);
      if (v.stat[0]) chk(err_cyc == stat_cyc + 1, "R7 error read timing", err_cyc, stat_cyc + 1);
      chk(done_cnt == 1, "R8 single done pulse", done_cnt, 1);
      chk(done_stat == v.stat, "R8 status at done", done_stat, v.stat);
      chk(done_err == (v.stat[0] ? v.errv : 8'h00), "R7 error byte", done_err, v.stat[0] ? v.errv : 8'h00);
      chk(!busy, "R9 busy drops after done", busy, 0);
      chk(stat_o == v.stat, "R8 status held", stat_o, v.stat);
      chk(idle_act == 0, "R9 activity outside busy", idle_act, 0);
      chk(v.wr ? (pops == limit && pushes == 0) : (pushes == limit && pops == 0),
          "R10 host strobe direction", v.wr ? pops : pushes, limit);
      chk(data_bad == 0, "R10 data path", data_bad, 0);
   endtask

   initial begin
      repeat (3) tick();
      chk(!busy && !done && !chan_arm && !chan_disarm, "R11 reset controls", {busy, done, chan_arm, chan_disarm}, 0);
      chk(!tf_wr && !tf_rd && !dma_ack && !proto_err, "R11 reset bus", {tf_wr, tf_rd, dma_ack, proto_err}, 0);
      chk(stat_o == 0 && err_o == 0, "R11 reset bytes", {stat_o, err_o}, 0);
      rst_n = 1;
      tick(); tick();
      chk(!busy, "R11 idle after reset", busy, 0);

      for (int i = 0; i < NV; i++) begin
         run_cmd(VECS[i], i, 0);
         repeat (3) tick();
      end

      // R3: request held after the count is met gets no acknowledge
      run_cmd('{1'b1, 8'd1, 16'd64, 1'b0, 1'b0, 8'h50, 8'h00}, 6, 6);
      repeat (3) tick();
      // R3: count zero means 256 sectors
      run_cmd('{1'b0, 8'd0, 16'd4096, 1'b1, 1'b0, 8'h50, 8'h00}, 7, 0);

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         tests++; fails++;
         $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule